// File: doc/BRIEF.md
# USB Endpoint Handshake Control

This block holds the control and status state for five endpoints of a USB device function: a control endpoint (endpoint 0) and four general endpoints. Each endpoint has one 8-bit register that the CPU reads and writes over a simple register bus. The serial interface engine reports two kinds of events. The first is a received token together with the length of any OUT or SETUP data packet that arrived with good CRC. The second is the host acknowledging data that was sent on an IN endpoint.

For each token the block picks the handshake: no answer, ACK, NAK or STALL. It updates the endpoint's data-valid and transfer-done flags and raises an interrupt request while any done flag is set. Two CPU-owned flags decide the answer. The done flag blocks all traffic on its endpoint. The valid flag means "armed to send" on an IN endpoint and "data waiting for the CPU" on an OUT endpoint. The CPU clears both flags by writing zero. Hardware clears an IN endpoint's valid flag after the host acknowledges the data.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset every endpoint register reads 0x00, `hs_code` is 2'b00 and `irq` is 0.
- R2: Register address 0 selects endpoint 0 and addresses 1 to 4 select general endpoints 1 to 4. A general register reads {0, mode[1:0], dir, size[1:0], valid, done} from bit 7 down to bit 0. Endpoint 0 reads {0, 0, 0, in_armed, size[1:0], out_valid, done}. Bit 7 always reads 0. Addresses above 4 read 0x00 and writes to them change nothing.
- R3: The done flag (bit 0) and the OUT-side valid flag (bit 1; endpoint 0's bit 1) are cleared only by a CPU write of 0 to that bit. Writing 1 leaves them unchanged. On a general IN endpoint (dir=1), the CPU writes bit 1 directly.
- R4: A register write copies bit 7 into the endpoint's stall request, so 1 sets it and 0 clears it. A stalled endpoint answers every IN or OUT token with STALL, ahead of any NAK or ACK rule, and its flags do not change.
- R5: While an endpoint's done flag is set, every IN or OUT token to it is answered with NAK.
- R6: An IN token to an IN endpoint is answered with NAK while the armed flag is clear and with ACK while it is set. The armed flag is valid (bit 1) on a general endpoint and in_armed (bit 4) on endpoint 0.
- R7: An IN acknowledge event for an IN endpoint clears its armed flag and sets its done flag.
- R8: An OUT packet that is accepted gets ACK and sets both valid and done. While valid is set, later OUT tokens to that endpoint are answered with NAK.
- R9: The size field selects a maximum packet length of 8 << size bytes. An OUT packet longer than that gets NAK and sets no flag. A packet of exactly the maximum length is accepted.
- R10: A SETUP token to endpoint 0 is always answered with ACK, even while stalled or done. It sets out_valid and done and clears the stall request. A SETUP token to any other endpoint, a token with the reserved PID code, and a token to an endpoint number above 4 get no answer (2'b00).
- R11: A token whose direction does not match a general endpoint's dir bit gets NAK. An IN acknowledge event for an OUT endpoint is ignored.
- R12: `irq` is 1 exactly while at least one endpoint's done flag is set.
- R13: When a hardware flag update and a CPU write to the same register fall in the same cycle, the hardware update of valid and done wins.
- R14: `hs_code` shows the answer in the cycle after the `tok_vld` cycle and is 2'b00 otherwise. The encoding is ACK=2'b01, NAK=2'b10, STALL=2'b11. The PID codes are OUT=2'b00, IN=2'b01, SETUP=2'b11, and 2'b10 is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select (endpoint number) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tok_vld | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token kind |
| tok_ep | input | 3 | Token endpoint number |
| tok_len | input | 7 | Data packet length for OUT/SETUP |
| in_ack_vld | input | 1 | Host acknowledged IN data |
| in_ack_ep | input | 3 | Endpoint of the IN acknowledge |
| hs_code | output | 2 | Registered handshake answer |
| irq | output | 1 | Any endpoint done |

## Verification
The hardest case to reach is a CPU write and a hardware flag update landing on the same register in the same clock. The register bus and the event inputs are independent, so this only happens when both are driven in the same cycle. One scenario task drives a zero-write together with an accepted OUT token. Another drives a re-arm write together with an IN acknowledge. Both then read the register back to see which update survived. A stall request combined with a pending done flag also needs care: the endpoint must first be brought to the done state through a real IN transfer, and only then is the stall bit written.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    PID_OUT   = 2'b00,
    PID_IN    = 2'b01,
    PID_RSV   = 2'b10,
    PID_SETUP = 2'b11
  } pid_e;

  localparam int REG_W   = 8;
  localparam int B_STALL = 7;
  localparam int B_ARM   = 4;
  localparam int B_DIR   = 4;
  localparam int B_VALID = 1;
  localparam int B_DONE  = 0;

  // maximum packet length selected by the two size bits
  function automatic int unsigned max_pkt(input logic [1:0] sz);
    return 32'd8 << sz;
  endfunction

  function automatic logic len_fits(input int unsigned len, input logic [1:0] sz);
    return len <= max_pkt(sz);
  endfunction
endpackage

// File: rtl/usb_ep_csr.sv
module usb_ep_csr
  import usb_ep_pkg::*;
#(
  parameter bit CTRL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             rx_set_i,
  input  logic             tx_set_i,
  input  logic             setup_i,
  output logic             stall_o,
  output logic             done_o,
  output logic             in_rdy_o,
  output logic             out_busy_o,
  output logic             in_en_o,
  output logic             out_en_o,
  output logic [1:0]       size_o,
  output logic [REG_W-1:0] rd_o
);
  logic       stall_q, done_q, valid_q;
  logic [1:0] size_q;
  logic       in_en, cpu_arm, tx_clr;

  generate
    if (CTRL) begin : g_ctrl
      logic armed_q;
      logic ctrl_unused;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (tx_set_i) armed_q <= 1'b0;
        else if (wr_i)     armed_q <= wdata_i[B_ARM];
      end
      assign in_en       = 1'b1;
      assign out_en_o    = 1'b1;
      assign in_rdy_o    = armed_q;
      assign cpu_arm     = 1'b0;
      assign tx_clr      = 1'b0;
      assign rd_o        = {3'b000, armed_q, size_q, valid_q, done_q};
      assign ctrl_unused = ^wdata_i[6:5];
    end else begin : g_gen
      logic [1:0] mode_q;
      logic       dir_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q <= 2'b00;
          dir_q  <= 1'b0;
        end else if (wr_i) begin
          mode_q <= wdata_i[6:5];
          dir_q  <= wdata_i[B_DIR];
        end
      end
      assign in_en    = dir_q;
      assign out_en_o = ~dir_q;
      assign in_rdy_o = dir_q & valid_q;
      assign cpu_arm  = dir_q;
      assign tx_clr   = 1'b1;
      assign rd_o     = {1'b0, mode_q, dir_q, size_q, valid_q, done_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      size_q  <= 2'b00;
    end else begin
      if (wr_i) begin
        stall_q <= wdata_i[B_STALL];
        size_q  <= wdata_i[3:2];
        done_q  <= done_q & wdata_i[B_DONE];
        valid_q <= cpu_arm ? wdata_i[B_VALID] : (valid_q & wdata_i[B_VALID]);
      end
      // hardware updates come last so they win over a same-cycle write (R13)
      if (setup_i) stall_q <= 1'b0;
      if (rx_set_i) begin
        valid_q <= 1'b1;
        done_q  <= 1'b1;
      end
      if (tx_set_i && in_en) begin
        done_q <= 1'b1;
        if (tx_clr) valid_q <= 1'b0;
      end
    end
  end

  assign stall_o    = stall_q;
  assign done_o     = done_q;
  assign out_busy_o = valid_q;
  assign in_en_o    = in_en;
  assign size_o     = size_q;
endmodule

// File: rtl/usb_ep_hs_decide.sv
module usb_ep_hs_decide
  import usb_ep_pkg::*;
#(
  parameter int NEP = 5,
  parameter int AW  = 3,
  parameter int LW  = 7
) (
  input  logic                tok_vld,
  input  logic [1:0]          tok_pid,
  input  logic [AW-1:0]       tok_ep,
  input  logic [LW-1:0]       tok_len,
  input  logic [NEP-1:0]      stall_v,
  input  logic [NEP-1:0]      done_v,
  input  logic [NEP-1:0]      in_rdy_v,
  input  logic [NEP-1:0]      out_busy_v,
  input  logic [NEP-1:0]      in_en_v,
  input  logic [NEP-1:0]      out_en_v,
  input  logic [NEP-1:0][1:0] size_v,
  output logic [1:0]          hs_o,
  output logic [NEP-1:0]      rx_set_o,
  output logic                setup_o
);
  hs_e hs;

  always_comb begin
    hs       = HS_NONE;
    rx_set_o = '0;
    setup_o  = 1'b0;
    for (int e = 0; e < NEP; e++) begin
      if (tok_vld && tok_ep == AW'(e)) begin
        case (tok_pid)
          PID_SETUP: begin
            if (e == 0) begin
              hs          = HS_ACK;
              rx_set_o[e] = 1'b1;
              setup_o     = 1'b1;
            end
          end
          PID_IN: begin
            if (stall_v[e])                                 hs = HS_STALL;
            else if (!in_en_v[e] || done_v[e] || !in_rdy_v[e]) hs = HS_NAK;
            else                                            hs = HS_ACK;
          end
          PID_OUT: begin
            if (stall_v[e]) hs = HS_STALL;
            else if (!out_en_v[e] || done_v[e] || out_busy_v[e] ||
                     !len_fits(32'(tok_len), size_v[e])) hs = HS_NAK;
            else begin
              hs          = HS_ACK;
              rx_set_o[e] = 1'b1;
            end
          end
          default: hs = HS_NONE;
        endcase
      end
    end
  end

  assign hs_o = hs;
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
  import usb_ep_pkg::*;
#(
  parameter int N_GEN = 4,
  parameter int LW    = 7,
  localparam int NEP  = N_GEN + 1,
  localparam int AW   = $clog2(NEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tok_vld,
  input  logic [1:0]       tok_pid,
  input  logic [AW-1:0]    tok_ep,
  input  logic [LW-1:0]    tok_len,
  input  logic             in_ack_vld,
  input  logic [AW-1:0]    in_ack_ep,
  output logic [1:0]       hs_code,
  output logic             irq
);
  // named internal events, observed by the bound checker
  logic [NEP-1:0]      stall_v, done_v, in_rdy_v, out_busy_v, in_en_v, out_en_v;
  logic [NEP-1:0]      rx_set_v, tx_set_v;
  logic [NEP-1:0][1:0] size_v;
  logic [REG_W-1:0]    rd_v [NEP];
  logic                setup_hit;
  logic [1:0]          hs_next, hs_q;

  generate
    for (genvar e = 0; e < NEP; e++) begin : g_ep
      assign tx_set_v[e] = in_ack_vld && (in_ack_ep == AW'(e));
      usb_ep_csr #(.CTRL(e == 0)) csr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr && (reg_addr == AW'(e))),
        .wdata_i    (reg_wdata),
        .rx_set_i   (rx_set_v[e]),
        .tx_set_i   (tx_set_v[e]),
        .setup_i    ((e == 0) && setup_hit),
        .stall_o    (stall_v[e]),
        .done_o     (done_v[e]),
        .in_rdy_o   (in_rdy_v[e]),
        .out_busy_o (out_busy_v[e]),
        .in_en_o    (in_en_v[e]),
        .out_en_o   (out_en_v[e]),
        .size_o     (size_v[e]),
        .rd_o       (rd_v[e])
      );
    end
  endgenerate

  usb_ep_hs_decide #(.NEP(NEP), .AW(AW), .LW(LW)) dec_i (
    .tok_vld    (tok_vld),
    .tok_pid    (tok_pid),
    .tok_ep     (tok_ep),
    .tok_len    (tok_len),
    .stall_v    (stall_v),
    .done_v     (done_v),
    .in_rdy_v   (in_rdy_v),
    .out_busy_v (out_busy_v),
    .in_en_v    (in_en_v),
    .out_en_v   (out_en_v),
    .size_v     (size_v),
    .hs_o       (hs_next),
    .rx_set_o   (rx_set_v),
    .setup_o    (setup_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 2'b00;
    else        hs_q <= hs_next;
  end

  always_comb begin
    reg_rdata = '0;
    for (int e = 0; e < NEP; e++)
      if (reg_addr == AW'(e)) reg_rdata = rd_v[e];
  end

  assign hs_code = hs_q;
  assign irq     = |done_v;
endmodule

// File: rtl/usb_ep_hs_chk.sv
module usb_ep_hs_chk #(
  parameter int NEP = 5,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tok_vld,
  input logic [1:0]     tok_pid,
  input logic [AW-1:0]  tok_ep,
  input logic [1:0]     hs_code,
  input logic           irq,
  input logic [NEP-1:0] done_v,
  input logic [NEP-1:0] stall_v,
  input logic [NEP-1:0] rx_set_v,
  input logic [NEP-1:0] tx_set_v
);
  logic data_tok, ep_ok, ep_stall, ep_done;
  assign data_tok = (tok_pid == 2'b00) || (tok_pid == 2'b01);
  assign ep_ok    = 32'(tok_ep) < NEP;
  assign ep_stall = ep_ok && stall_v[tok_ep];
  assign ep_done  = ep_ok && done_v[tok_ep];

  assert_hs_after_tok_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != 2'b00) |-> $past(tok_vld));

  assert_stall_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && data_tok && ep_stall) |=> (hs_code == 2'b11));

  assert_done_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && data_tok && ep_done && !ep_stall) |=> (hs_code == 2'b10));

  assert_hw_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_set_v) |=> ((done_v & $past(rx_set_v)) == $past(rx_set_v)));

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(rx_set_v | tx_set_v)));

  assert_nak_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == 2'b10) |-> ($past(rx_set_v) == '0));
endmodule

bind usb_ep_hs_ctrl usb_ep_hs_chk #(.NEP(NEP), .AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tok_vld  (tok_vld),
  .tok_pid  (tok_pid),
  .tok_ep   (tok_ep),
  .hs_code  (hs_code),
  .irq      (irq),
  .done_v   (done_v),
  .stall_v  (stall_v),
  .rx_set_v (rx_set_v),
  .tx_set_v (tx_set_v)
);

// File: tb/usb_ep_hs_ctrl_tb_top.sv
module usb_ep_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] P_OUT = 2'b00, P_IN = 2'b01, P_RSV = 2'b10, P_SETUP = 2'b11;
  localparam logic [1:0] H_NONE = 2'b00, H_ACK = 2'b01, H_NAK = 2'b10, H_STALL = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tok_vld = 1'b0;
  logic [1:0] tok_pid = '0;
  logic [2:0] tok_ep = '0;
  logic [6:0] tok_len = '0;
  logic       in_ack_vld = 1'b0;
  logic [2:0] in_ack_ep = '0;
  logic [1:0] hs_code;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_hs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_vld(tok_vld),
    .tok_pid(tok_pid), .tok_ep(tok_ep), .tok_len(tok_len),
    .in_ack_vld(in_ack_vld), .in_ack_ep(in_ack_ep), .hs_code(hs_code), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, $sformatf("reg[%0d]", a), int'(reg_rdata), int'(exp));
  endtask

  task automatic tok(input string req, input logic [1:0] pid, input logic [2:0] ep,
                     input logic [6:0] len, input logic [1:0] exp);
    @(negedge clk);
    tok_vld = 1'b1; tok_pid = pid; tok_ep = ep; tok_len = len;
    @(negedge clk);
    tok_vld = 1'b0;
    check(req, $sformatf("hs pid=%0d ep=%0d len=%0d", pid, ep, len), int'(hs_code), int'(exp));
  endtask

  task automatic ack_in(input logic [2:0] ep);
    @(negedge clk);
    in_ack_vld = 1'b1; in_ack_ep = ep;
    @(negedge clk);
    in_ack_vld = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a), 8'h00);
    check("R1", "hs_code", int'(hs_code), 0);
    check("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_map;
    wr(3'd1, 8'h54); rd_chk("R2", 3'd1, 8'h54);
    wr(3'd4, 8'h2C); rd_chk("R2", 3'd4, 8'h2C);
    wr(3'd0, 8'h6C); rd_chk("R2", 3'd0, 8'h0C);
    wr(3'd5, 8'hFF); rd_chk("R2", 3'd5, 8'h00);
    rd_chk("R2", 3'd1, 8'h54); rd_chk("R2", 3'd4, 8'h2C);
    rd_chk("R2", 3'd2, 8'h00); rd_chk("R2", 3'd0, 8'h0C);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
  endtask

  task automatic t_in;
    wr(3'd2, 8'h10);
    tok("R6", P_IN, 3'd2, 7'd0, H_NAK);
    wr(3'd2, 8'h12); rd_chk("R6", 3'd2, 8'h12);
    tok("R6", P_IN, 3'd2, 7'd0, H_ACK);
    rd_chk("R6", 3'd2, 8'h12);
    ack_in(3'd2);
    rd_chk("R7", 3'd2, 8'h11);
    check("R12", "irq after IN done", int'(irq), 1);
    tok("R5", P_IN, 3'd2, 7'd0, H_NAK);
    wr(3'd2, 8'h10); rd_chk("R3", 3'd2, 8'h10);
    check("R12", "irq after clear", int'(irq), 0);
  endtask

  task automatic t_out;
    wr(3'd3, 8'h04);
    tok("R9", P_OUT, 3'd3, 7'd17, H_NAK);
    rd_chk("R9", 3'd3, 8'h04);
    tok("R9", P_OUT, 3'd3, 7'd16, H_ACK);
    rd_chk("R8", 3'd3, 8'h07);
    wr(3'd3, 8'h07); rd_chk("R3", 3'd3, 8'h07);
    wr(3'd3, 8'h06); rd_chk("R3", 3'd3, 8'h06);
    tok("R8", P_OUT, 3'd3, 7'd1, H_NAK);
    rd_chk("R8", 3'd3, 8'h06);
    wr(3'd3, 8'h04); rd_chk("R3", 3'd3, 8'h04);
    tok("R8", P_OUT, 3'd3, 7'd0, H_ACK);
    wr(3'd3, 8'h0C);
    tok("R9", P_OUT, 3'd3, 7'd64, H_ACK);
    wr(3'd3, 8'h0C);
    tok("R9", P_OUT, 3'd3, 7'd65, H_NAK);
    rd_chk("R9", 3'd3, 8'h0C);
  endtask

  task automatic t_dir;
    tok("R11", P_IN, 3'd3, 7'd0, H_NAK);
    wr(3'd2, 8'h12);
    tok("R11", P_OUT, 3'd2, 7'd1, H_NAK);
    rd_chk("R11", 3'd2, 8'h12);
    ack_in(3'd3);
    rd_chk("R11", 3'd3, 8'h0C);
    check("R11", "irq after ignored ack", int'(irq), 0);
    wr(3'd2, 8'h10);
  endtask

  task automatic t_stall;
    wr(3'd1, 8'h80); rd_chk("R4", 3'd1, 8'h00);
    tok("R4", P_OUT, 3'd1, 7'd1, H_STALL);
    tok("R4", P_IN, 3'd1, 7'd0, H_STALL);
    rd_chk("R4", 3'd1, 8'h00);
    wr(3'd2, 8'h12);
    tok("R4", P_IN, 3'd2, 7'd0, H_ACK);
    ack_in(3'd2);
    wr(3'd2, 8'h91); rd_chk("R4", 3'd2, 8'h11);
    tok("R4", P_IN, 3'd2, 7'd0, H_STALL);
    wr(3'd2, 8'h10);
    tok("R4", P_IN, 3'd2, 7'd0, H_NAK);
    wr(3'd1, 8'h00);
    tok("R4", P_OUT, 3'd1, 7'd8, H_ACK);
    wr(3'd3, 8'h0F);
    tok("R12", P_OUT, 3'd3, 7'd1, H_ACK);
    wr(3'd1, 8'h00);
    check("R12", "irq with one done left", int'(irq), 1);
    wr(3'd3, 8'h0C);
    check("R12", "irq all clear", int'(irq), 0);
  endtask

  task automatic t_ep0;
    wr(3'd0, 8'h80);
    tok("R4", P_OUT, 3'd0, 7'd1, H_STALL);
    tok("R10", P_SETUP, 3'd0, 7'd8, H_ACK);
    rd_chk("R10", 3'd0, 8'h03);
    tok("R10", P_OUT, 3'd0, 7'd1, H_NAK);
    wr(3'd0, 8'h00); rd_chk("R10", 3'd0, 8'h00);
    tok("R6", P_IN, 3'd0, 7'd0, H_NAK);
    wr(3'd0, 8'h10);
    tok("R6", P_IN, 3'd0, 7'd0, H_ACK);
    ack_in(3'd0);
    rd_chk("R7", 3'd0, 8'h01);
    tok("R10", P_SETUP, 3'd1, 7'd8, H_NONE);
    tok("R10", P_RSV, 3'd0, 7'd1, H_NONE);
    tok("R10", P_OUT, 3'd5, 7'd1, H_NONE);
    tok("R10", P_SETUP, 3'd0, 7'd8, H_ACK);
    rd_chk("R10", 3'd0, 8'h03);
    @(negedge clk);
    check("R14", "hs returns to none", int'(hs_code), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_race;
    wr(3'd1, 8'h00);
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
    tok_vld = 1'b1; tok_pid = P_OUT; tok_ep = 3'd1; tok_len = 7'd1;
    @(negedge clk);
    reg_wr = 1'b0; tok_vld = 1'b0;
    check("R13", "hs on racing OUT", int'(hs_code), int'(H_ACK));
    rd_chk("R13", 3'd1, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h12);
    @(negedge clk);
    reg_addr = 3'd2; reg_wdata = 8'h12; reg_wr = 1'b1;
    in_ack_vld = 1'b1; in_ack_ep = 3'd2;
    @(negedge clk);
    reg_wr = 1'b0; in_ack_vld = 1'b0;
    rd_chk("R13", 3'd2, 8'h11);
    wr(3'd2, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_in();
    t_out();
    t_dir();
    t_stall();
    t_ep0();
    t_race();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule